// File: doc/BRIEF.md
# PLL Mode and Divider Controller

This block is the register-side control for a clock PLL. It keeps a multiplier value, a divider-select field and a power-down bit. It moves the PLL through four modes: off, bypass, locking and enabled. It tells the clock tree whether to take the raw oscillator clock or the PLL clock, and which divide ratio (1, 2 or 4) to apply. The analog PLL and the clock dividers are outside the block. The PLL reports lock through a single input. The block acts on the rising edge of that input.

Software writes either the multiplier register or the control register. The legality of a write depends on the current state. A multiplier write needs a divider select of zero and the PLL powered. A divider change needs a PLL that is not still locking. Powering down needs a multiplier of zero. Divide-by-1 cannot be used while the PLL clock is selected. An illegal write changes nothing and sets a sticky error flag. Software clears that flag by writing a 1 to the clear bit of the control register.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode is bypass (code 1), the multiplier is 0, the divider select is 0 (ratio 4), the raw oscillator clock is selected, and both the lock status and the error flag are 0.
- R2: In bypass, locking or off mode the divide ratio follows the divider select, which is bits [1:0] of the control register (address 1): 0 or 1 gives 4, 2 gives 2, 3 gives 1.
- R3: An accepted non-zero multiplier write (address 0, bits [3:0]) enters locking (code 2), with the raw clock selected and the lock status at 0. On the first clock edge with the lock input high after it was low, the mode becomes enabled (code 3), the PLL clock is selected and the lock status reads 1.
- R4: In enabled mode a divider select of 0 or 1 gives ratio 4 and 2 gives ratio 2. A write of select 3 is rejected.
- R5: A multiplier write is rejected when the divider select is not 0 or when the PLL is off.
- R6: A control write that changes the divider select while locking is rejected.
- R7: Setting the off bit (control bit 2) is accepted only while the multiplier is 0. Off mode is code 0, selects the raw clock and uses the R2 ratios.
- R8: Clearing the off bit while in off mode returns to bypass, with the multiplier still 0.
- R9: A rejected write leaves the multiplier, the divider select and the off bit unchanged and sets the error flag. The flag stays set until a control write with bit 3 set is accepted. When one write both is rejected and asks for the clear, the flag is set.
- R10: When an accepted multiplier write and a lock rise fall in the same cycle, the write wins: the mode is locking and the lock status is 0. When an accepted control write and a lock rise fall in the same cycle during locking, the rise still completes the lock.
- R11: An accepted zero multiplier write returns to bypass with the lock status at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the multiplier register, 1 selects the control register |
| wr_data | input | 4 | Write data |
| pll_lock_i | input | 1 | Lock indication from the PLL |
| mode_o | output | 2 | Mode: 0 off, 1 bypass, 2 locking, 3 enabled |
| pll_clk_sel_o | output | 1 | 1 selects the PLL clock, 0 selects the raw oscillator |
| div_ratio_o | output | 3 | Active divide ratio: 1, 2 or 4 |
| mult_o | output | 4 | Multiplier value driven to the PLL |
| lock_sts_o | output | 1 | Lock status bit |
| err_o | output | 1 | Sticky illegal-write flag |

## Verification
A register write and a lock rise can land on the same clock edge. The write may also undo the lock that the rise is trying to complete. The bench holds the controller in locking and then raises the lock input in the same cycle as a new multiplier write. It checks that the mode stays locking, that the lock status stays 0 and that the new multiplier is taken. It then repeats the case with an error-clearing control write, where the mode must become enabled and the flag must clear.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

    localparam int CTRL_W       = 4;
    localparam int CTRL_OFF_BIT = 2;
    localparam int CTRL_CLR_BIT = 3;
    localparam logic ADDR_MULT  = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_BYPASS  = 2'd1,
        MODE_LOCKING = 2'd2,
        MODE_ENABLED = 2'd3
    } pll_mode_e;

    typedef struct packed {
        logic mult_wr;   // accepted multiplier write
        logic ctrl_wr;   // accepted control write
        logic reject;    // illegal write seen
        logic err_clr;   // clear request on the error flag
    } wr_dec_t;

    function automatic logic [2:0] ratio_of(input logic [1:0] sel, input logic pll_active);
        logic [2:0] r;
        case (sel)
            2'd2:    r = 3'd2;
            2'd3:    r = pll_active ? 3'd4 : 3'd1;
            default: r = 3'd4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pll_wr_check.sv
module pll_wr_check
    import pll_mode_pkg::*;
#(
    parameter int MULT_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  pll_mode_e         mode,
    input  logic [MULT_W-1:0] mult_q,
    input  logic [1:0]        sel_q,
    input  logic              off_q,
    output wr_dec_t           dec,
    output logic [MULT_W-1:0] new_mult,
    output logic [1:0]        new_sel,
    output logic              new_off
);

    logic mult_bad;
    logic ctrl_bad;
    logic sel_moves;

    always_comb begin
        new_mult  = wr_data[MULT_W-1:0];
        new_sel   = wr_data[1:0];
        new_off   = wr_data[CTRL_OFF_BIT];
        sel_moves = (new_sel != sel_q);

        mult_bad = (sel_q != 2'd0) || off_q;
        ctrl_bad = (sel_moves && mode == MODE_LOCKING)
                || (new_off && mult_q != '0)
                || (mode == MODE_ENABLED && new_sel == 2'd3);

        dec.mult_wr = wr_en && (wr_addr == ADDR_MULT) && !mult_bad;
        dec.ctrl_wr = wr_en && (wr_addr == ADDR_CTRL) && !ctrl_bad;
        dec.reject  = wr_en && ((wr_addr == ADDR_MULT) ? mult_bad : ctrl_bad);
        dec.err_clr = wr_en && (wr_addr == ADDR_CTRL) && wr_data[CTRL_CLR_BIT];
    end

endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_mode_pkg::*;
#(
    parameter int MULT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_dec_t           dec,
    input  logic [MULT_W-1:0] new_mult,
    input  logic [1:0]        new_sel,
    input  logic              new_off,
    output logic [MULT_W-1:0] mult_q,
    output logic [1:0]        sel_q,
    output logic              off_q,
    output logic              err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_q <= '0;
            sel_q  <= 2'd0;
            off_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (dec.mult_wr) begin
                mult_q <= new_mult;
            end
            if (dec.ctrl_wr) begin
                sel_q <= new_sel;
                off_q <= new_off;
            end
            if (dec.reject) begin
                err_q <= 1'b1;
            end else if (dec.err_clr) begin
                err_q <= 1'b0;
            end
        end
    end

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        dec.reject |=> ($stable(mult_q) && $stable(sel_q) && $stable(off_q))); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !dec.err_clr) |=> err_q); // R9
    AST_OFF_ZERO_MULT: assert property (@(posedge clk) disable iff (rst)
        off_q |-> (mult_q == '0)); // R7

endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
    import pll_mode_pkg::*;
#(
    parameter int MULT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_dec_t           dec,
    input  logic [MULT_W-1:0] new_mult,
    input  logic              new_off,
    input  logic              lock_i,
    output pll_mode_e         mode,
    output logic              lock_sts
);

    pll_mode_e mode_n;
    logic      lock_n;
    logic      lock_d;
    logic      lock_rise;

    assign lock_rise = lock_i && !lock_d;

    always_comb begin
        mode_n = mode;
        lock_n = lock_sts;
        if (mode == MODE_LOCKING && lock_rise) begin
            mode_n = MODE_ENABLED;
            lock_n = 1'b1;
        end
        if (dec.ctrl_wr) begin
            if (new_off) begin
                mode_n = MODE_OFF;
            end else if (mode == MODE_OFF) begin
                mode_n = MODE_BYPASS;
            end
        end
        if (dec.mult_wr) begin
            mode_n = (new_mult != '0) ? MODE_LOCKING : MODE_BYPASS;
            lock_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_BYPASS;
            lock_sts <= 1'b0;
            lock_d   <= 1'b0;
        end else begin
            mode     <= mode_n;
            lock_sts <= lock_n;
            lock_d   <= lock_i;
        end
    end

    AST_LOCKING_NO_STS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOCKING) |-> !lock_sts); // R3
    AST_RISE_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOCKING && lock_rise && !dec.mult_wr && !dec.ctrl_wr)
        |=> (mode == MODE_ENABLED)); // R3
    AST_MULT_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        dec.mult_wr |=> !lock_sts); // R10

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
    import pll_mode_pkg::*;
#(
    parameter int MULT_W = 4,
    localparam int DATA_W = (MULT_W > CTRL_W) ? MULT_W : CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pll_lock_i,
    output logic [1:0]        mode_o,
    output logic              pll_clk_sel_o,
    output logic [2:0]        div_ratio_o,
    output logic [MULT_W-1:0] mult_o,
    output logic              lock_sts_o,
    output logic              err_o
);

    wr_dec_t           dec;
    logic [MULT_W-1:0] new_mult;
    logic [1:0]        new_sel;
    logic              new_off;
    logic [MULT_W-1:0] mult_q;
    logic [1:0]        sel_q;
    logic              off_q;
    logic              err_q;
    pll_mode_e         mode;
    logic              lock_sts;

    pll_wr_check #(.MULT_W(MULT_W), .DATA_W(DATA_W)) u_check (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode     (mode),
        .mult_q   (mult_q),
        .sel_q    (sel_q),
        .off_q    (off_q),
        .dec      (dec),
        .new_mult (new_mult),
        .new_sel  (new_sel),
        .new_off  (new_off)
    );

    pll_cfg_regs #(.MULT_W(MULT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .new_mult (new_mult),
        .new_sel  (new_sel),
        .new_off  (new_off),
        .mult_q   (mult_q),
        .sel_q    (sel_q),
        .off_q    (off_q),
        .err_q    (err_q)
    );

    pll_mode_fsm #(.MULT_W(MULT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .new_mult (new_mult),
        .new_off  (new_off),
        .lock_i   (pll_lock_i),
        .mode     (mode),
        .lock_sts (lock_sts)
    );

    assign mode_o        = mode;
    assign pll_clk_sel_o = (mode == MODE_ENABLED);
    assign div_ratio_o   = ratio_of(sel_q, mode == MODE_ENABLED);
    assign mult_o        = mult_q;
    assign lock_sts_o    = lock_sts;
    assign err_o         = err_q;

    AST_NO_DIV1_ENABLED: assert property (@(posedge clk) disable iff (rst)
        pll_clk_sel_o |-> (div_ratio_o != 3'd1)); // R4
    AST_PLL_CLK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        pll_clk_sel_o |-> lock_sts_o); // R3
    AST_OFF_RAW_CLK: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0) |-> (!pll_clk_sel_o && mult_o == '0)); // R7

endmodule

// File: tb/tb_pll_mode_ctrl.sv
module tb_pll_mode_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       pll_lock_i = 1'b0;
    logic [1:0] mode_o;
    logic       pll_clk_sel_o;
    logic [2:0] div_ratio_o;
    logic [3:0] mult_o;
    logic       lock_sts_o;
    logic       err_o;

    int n_run = 0;
    int n_fail = 0;
    int e_mode, e_mult, e_sel, e_off, e_err, e_lock;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_mode_ctrl dut (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .pll_lock_i    (pll_lock_i),
        .mode_o        (mode_o),
        .pll_clk_sel_o (pll_clk_sel_o),
        .div_ratio_o   (div_ratio_o),
        .mult_o        (mult_o),
        .lock_sts_o    (lock_sts_o),
        .err_o         (err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_ratio();
        if (e_mode == 3) return (e_sel == 2) ? 2 : 4;
        return (e_sel == 3) ? 1 : ((e_sel == 2) ? 2 : 4);
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " mode"}, int'(mode_o), e_mode);
        chk({tag, " clksel"}, int'(pll_clk_sel_o), (e_mode == 3) ? 1 : 0);
        chk({tag, " ratio"}, int'(div_ratio_o), exp_ratio());
        chk({tag, " mult"}, int'(mult_o), e_mult);
        chk({tag, " lock"}, int'(lock_sts_o), e_lock);
        chk({tag, " err"}, int'(err_o), e_err);
    endtask

    // reference behaviour of one write, taken from the requirements
    task automatic model_wr(input bit a, input int d);
        bit bad;
        int ns, no;
        if (a == 1'b0) begin
            bad = (e_sel != 0) || (e_off != 0);
            if (!bad) begin
                e_mult = d & 15;
                e_mode = (e_mult != 0) ? 2 : 1;
                e_lock = 0;
            end
        end else begin
            ns = d & 3;
            no = (d >> 2) & 1;
            bad = (ns != e_sel && e_mode == 2) || (no != 0 && e_mult != 0)
               || (e_mode == 3 && ns == 3);
            if (!bad) begin
                e_sel = ns;
                e_off = no;
                if (no != 0) e_mode = 0;
                else if (e_mode == 0) e_mode = 1;
            end
        end
        if (bad) e_err = 1;
        else if (a == 1'b1 && ((d >> 3) & 1) != 0) e_err = 0;
    endtask

    task automatic write_reg(input bit a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d[3:0];
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
    endtask

    task automatic lock_pulse();
        @(negedge clk);
        pll_lock_i = 1'b1;
        @(negedge clk);
        pll_lock_i = 1'b0;
        if (e_mode == 2) begin e_mode = 3; e_lock = 1; end
    endtask

    task automatic settle_lock();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        e_mode = 1; e_mult = 0; e_sel = 0; e_off = 0; e_err = 0; e_lock = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        // R2: bypass ratios for every select value
        for (int s = 0; s < 4; s++) begin
            write_reg(1'b1, s);
            check_all("R2 bypass select");
        end

        // R5: multiplier write with select 3 is rejected; R9: state kept, flag sticky
        write_reg(1'b0, 5);
        check_all("R5 mult write with select nonzero");
        repeat (3) @(negedge clk);
        check_all("R9 error flag sticky");
        write_reg(1'b1, 3 | 8);
        check_all("R9 error clear");

        // R7: off mode with every select, R5: mult write while off, R8: leave off
        for (int s = 0; s < 4; s++) begin
            write_reg(1'b1, s | 4);
            check_all("R7 off mode ratio");
        end
        write_reg(1'b1, 0 | 4);
        write_reg(1'b0, 6);
        check_all("R5 mult write while off");
        write_reg(1'b1, 8);
        check_all("R8 off cleared to bypass");

        // R3/R4 sweep over every non-zero multiplier
        for (int n = 1; n < 16; n++) begin
            write_reg(1'b0, n);
            check_all("R3 locking entered");
            repeat (3) @(negedge clk);
            check_all("R3 waits for lock");
            lock_pulse();
            check_all("R3 enabled after lock");
            settle_lock();
            write_reg(1'b1, 2);
            check_all("R4 enabled select 2");
            write_reg(1'b1, 3);
            check_all("R4 enabled select 3 rejected");
            write_reg(1'b1, 1 | 4);
            check_all("R7 off refused with mult nonzero");
            write_reg(1'b1, 1);
            check_all("R4 enabled select 1");
            write_reg(1'b1, 8);
            check_all("R9 clear in enabled");
        end

        // R6: select change during locking
        write_reg(1'b0, 4);
        write_reg(1'b1, 2);
        check_all("R6 select change while locking");
        write_reg(1'b1, 8);
        check_all("R6 same select accepted while locking");

        // R11: zero multiplier write from locking
        write_reg(1'b0, 0);
        check_all("R11 zero mult to bypass");
        write_reg(1'b0, 9);
        lock_pulse();
        settle_lock();
        write_reg(1'b0, 0);
        check_all("R11 zero mult from enabled");

        // R10: collision of a multiplier write with a lock rise
        write_reg(1'b0, 7);
        check_all("R10 setup locking");
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 4'd3; pll_lock_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; pll_lock_i = 1'b0;
        e_mode = 2; e_mult = 3; e_lock = 0;
        check_all("R10 mult write beats lock rise");
        settle_lock();
        lock_pulse();
        check_all("R10 relock after collision");
        settle_lock();

        // R10: collision of an error-clearing control write with a lock rise
        write_reg(1'b1, 1);
        check_all("R10 setup error");
        write_reg(1'b1, 8);
        write_reg(1'b0, 5);
        write_reg(1'b1, 2);
        check_all("R10 setup error during locking");
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = 4'd8; pll_lock_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; pll_lock_i = 1'b0;
        e_mode = 3; e_lock = 1; e_err = 0;
        check_all("R10 control write with lock rise");
        settle_lock();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule